// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only control port of an imaging front end. A host sends 12-bit words over three wires: a serial clock, a serial data line and an active-low select strobe. Each word holds a 2-bit register address in its first two bits, followed by a 10-bit data field sent most significant bit first. The port writes one of four registers: a 9-bit gain code, an 8-bit auxiliary converter code, a 7-bit clamp reference code, and a 7-bit polarity flag set. All four drive parallel outputs.

All three serial lines and the vertical sync input are sampled in the system clock domain through a two-stage synchronizer. Serial clock edges are found by oversampling, so the system clock must run several times faster than the serial clock. A receive state machine has four states. ST_IDLE waits for the select line. ST_SHIFT takes one bit on each serial clock rise. ST_OVER holds a frame that has run past 12 bits until select is released. ST_LOAD is a single cycle that writes the decoded register. The transitions are:
- ST_IDLE to ST_SHIFT when select goes active.
- ST_SHIFT to ST_LOAD when select is released after exactly 12 bits.
- ST_SHIFT to ST_IDLE when select is released with any other count.
- ST_SHIFT to ST_OVER when a thirteenth bit arrives.
- ST_OVER to ST_IDLE when select is released.
- ST_LOAD to ST_IDLE unconditionally.

A gain write first lands in a hidden pending register. It reaches the gain output only on the selected edge of the vertical sync input. If the select line is wired to the sync input, the release of select is itself the sync edge, and the new gain takes effect at once.

Top module: `sctl_port`

## Requirements
- R1: After reset, gain_code, aux_code, clamp_code and pol_flags are all zero.
- R2: A frame is 12 bits long. Each bit is taken on a rising edge of ctl_sclk while ctl_sel_n is low, first bit first. The first two bits are the address, with the first bit as the address MSB. The remaining ten bits are data bits D9 down to D0.
- R3: Address 01 writes D7..D0 to aux_code. D9 and D8 have no effect.
- R4: Address 10 writes D6..D0 to clamp_code. D9..D7 have no effect.
- R5: Address 11 writes D6..D0 to pol_flags bits 6..0. D4 is unused, so pol_flags[4] always reads zero. D9..D7 have no effect.
- R6: A frame with fewer or more than 12 bits before ctl_sel_n rises changes no register.
- R7: Address 00 stores D8..D0 as a pending gain, and D9 has no effect. gain_code takes the pending value only on an active vsync_in edge. A gain write alone never changes gain_code.
- R8: pol_flags[6] picks the active sync edge: 0 means rising, 1 means falling. The other edge leaves gain_code unchanged.
- R9: If the active sync edge comes in the same system cycle that a gain frame is accepted (select wired to sync), gain_code takes that frame's value directly.
- R10: Register outputs change on the 4th system clock rising edge after the ctl_sel_n release (or the active vsync_in edge). ctl_sclk edges while ctl_sel_n is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial clock, asynchronous to clk |
| ctl_sdata | input | 1 | Serial data |
| ctl_sel_n | input | 1 | Active-low frame select |
| vsync_in | input | 1 | Vertical sync used to apply gain |
| gain_code | output | 9 | Active gain code |
| aux_code | output | 8 | Auxiliary converter code |
| clamp_code | output | 7 | Clamp reference code |
| pol_flags | output | 7 | Polarity flags, bit 4 reads zero |

## Verification
On every cycle, the assertions check three things: the aux, clamp and polarity outputs move only in the cycle after the single load pulse; the gain output moves only after a registered sync event; and neither pulse lasts more than one cycle. Only the bench's scenarios can show the rest. These are correct bit ordering and field masking, the rejection of short and long frames, which sync edge is active under each polarity setting, the same-cycle gain update when select is wired to sync, and the exact four-cycle latency. The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
    localparam int FRAME_BITS = 12;
    localparam int ADDR_BITS  = 2;
    localparam int DATA_BITS  = FRAME_BITS - ADDR_BITS;
    localparam int GAIN_BITS  = 9;
    localparam int AUX_BITS   = 8;
    localparam int CLAMP_BITS = 7;
    localparam int POL_BITS   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_OVER  = 2'd2,
        ST_LOAD  = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        SEL_GAIN  = 2'b00,
        SEL_AUX   = 2'b01,
        SEL_CLAMP = 2'b10,
        SEL_POL   = 2'b11
    } reg_sel_t;
endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
module sctl_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d_in};
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/sctl_frame_rx.sv
`timescale 1ns/1ps
module sctl_frame_rx
    import sctl_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               sel_n_s,
    output logic               load_o,
    output logic [FRAME_W-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    rx_state_t          state, nxt;
    logic               sclk_q;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shreg;
    logic               rise, active;

    assign rise   = sclk_s & ~sclk_q;
    assign active = ~sel_n_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (active) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (!active)                nxt = (cnt == FULL) ? ST_LOAD : ST_IDLE;
                else if (rise && cnt == FULL) nxt = ST_OVER;
            end
            ST_OVER:  if (!active) nxt = ST_IDLE;
            ST_LOAD:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state == ST_IDLE) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && active && rise && cnt != FULL) begin
                shreg <= {shreg[FRAME_W-2:0], sdat_s};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        load_o = (state == ST_LOAD);
        word_o = shreg;
    end
endmodule

// File: rtl/sctl_regs.sv
`timescale 1ns/1ps
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int                GAIN_W   = GAIN_BITS,
    parameter int                AUX_W    = AUX_BITS,
    parameter int                CLAMP_W  = CLAMP_BITS,
    parameter int                POL_W    = POL_BITS,
    parameter int                DATA_W   = DATA_BITS,
    parameter int                SYNC_BIT = 6,
    parameter logic [POL_W-1:0]  POL_MASK = 7'h6F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  data,
    input  logic               vs_s,
    output logic [GAIN_W-1:0]  gain_o,
    output logic [AUX_W-1:0]   aux_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic [POL_W-1:0]   pol_o,
    output logic               vs_evt_o
);
    logic [GAIN_W-1:0] gain_pend;
    logic              vs_q;
    logic              gain_now;

    assign gain_now = load && (reg_sel_t'(addr) == SEL_GAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q     <= 1'b0;
            vs_evt_o <= 1'b0;
        end else begin
            vs_q     <= vs_s;
            vs_evt_o <= pol_o[SYNC_BIT] ? (vs_q & ~vs_s) : (~vs_q & vs_s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_pend <= '0;
            aux_o     <= '0;
            clamp_o   <= '0;
            pol_o     <= '0;
        end else if (load) begin
            unique case (reg_sel_t'(addr))
                SEL_GAIN:  gain_pend <= data[GAIN_W-1:0];
                SEL_AUX:   aux_o     <= data[AUX_W-1:0];
                SEL_CLAMP: clamp_o   <= data[CLAMP_W-1:0];
                SEL_POL:   pol_o     <= data[POL_W-1:0] & POL_MASK;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gain_o <= '0;
        else if (vs_evt_o) gain_o <= gain_now ? data[GAIN_W-1:0] : gain_pend;
    end
endmodule

// File: rtl/sctl_port.sv
`timescale 1ns/1ps
module sctl_port
    import sctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_sclk,
    input  logic                  ctl_sdata,
    input  logic                  ctl_sel_n,
    input  logic                  vsync_in,
    output logic [GAIN_BITS-1:0]  gain_code,
    output logic [AUX_BITS-1:0]   aux_code,
    output logic [CLAMP_BITS-1:0] clamp_code,
    output logic [POL_BITS-1:0]   pol_flags
);
    logic [3:0]            sync_q;
    logic                  load_pulse;
    logic                  vs_evt;
    logic [FRAME_BITS-1:0] word;

    sctl_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b0100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({vsync_in, ctl_sel_n, ctl_sdata, ctl_sclk}),
        .d_out (sync_q)
    );

    sctl_frame_rx #(.FRAME_W(FRAME_BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_q[0]),
        .sdat_s  (sync_q[1]),
        .sel_n_s (sync_q[2]),
        .load_o  (load_pulse),
        .word_o  (word)
    );

    sctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .addr     (word[FRAME_BITS-1 -: ADDR_BITS]),
        .data     (word[DATA_BITS-1:0]),
        .vs_s     (sync_q[3]),
        .gain_o   (gain_code),
        .aux_o    (aux_code),
        .clamp_o  (clamp_code),
        .pol_o    (pol_flags),
        .vs_evt_o (vs_evt)
    );
endmodule

// File: rtl/sctl_port_chk.sv
`timescale 1ns/1ps
module sctl_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_pulse,
    input logic       vs_evt,
    input logic [8:0] gain_code,
    input logic [7:0] aux_code,
    input logic [6:0] clamp_code,
    input logic [6:0] pol_flags
);
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);                                   // R10
    AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(aux_code));                            // R3
    AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(clamp_code));                          // R4
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(pol_flags));                           // R5
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_evt |=> $stable(gain_code));                               // R7
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> !vs_evt);                                           // R8
endmodule

bind sctl_port sctl_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_pulse (load_pulse),
    .vs_evt     (vs_evt),
    .gain_code  (gain_code),
    .aux_code   (aux_code),
    .clamp_code (clamp_code),
    .pol_flags  (pol_flags)
);

// File: tb/sctl_port_tb.sv
`timescale 1ns/1ps
module sctl_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic       sel_n = 1'b1;
    logic       vsync = 1'b0;
    logic [8:0] gain_code;
    logic [7:0] aux_code;
    logic [6:0] clamp_code;
    logic [6:0] pol_flags;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit run = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [8:0] exp_gain = '0, exp_pend = '0;
    logic [7:0] exp_aux = '0;
    logic [6:0] exp_clamp = '0, exp_pol = '0;

    int          q_due[$];
    int          q_kind[$];
    logic [11:0] q_val[$];

    always #2 clk = ~clk;

    sctl_port u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_sclk(sclk), .ctl_sdata(sdata),
        .ctl_sel_n(sel_n), .vsync_in(vsync), .gain_code(gain_code),
        .aux_code(aux_code), .clamp_code(clamp_code), .pol_flags(pol_flags)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural model: apply due events, then compare every output
    always @(negedge clk) begin
        if (run) begin
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                int          k;
                logic [11:0] v;
                k = q_kind[0];
                v = q_val[0];
                void'(q_due.pop_front());
                void'(q_kind.pop_front());
                void'(q_val.pop_front());
                if (k == 1) exp_gain = exp_pend;
                else begin
                    case (v[11:10])
                        2'b00: exp_pend  = v[8:0];
                        2'b01: exp_aux   = v[7:0];
                        2'b10: exp_clamp = v[6:0];
                        default: exp_pol = v[6:0] & 7'h6F;
                    endcase
                end
            end
            chk(gain_code == exp_gain, cur_tag, "gain", int'(gain_code), int'(exp_gain));
            chk(aux_code == exp_aux, cur_tag, "aux", int'(aux_code), int'(exp_aux));
            chk(clamp_code == exp_clamp, cur_tag, "clamp", int'(clamp_code), int'(exp_clamp));
            chk(pol_flags == exp_pol, cur_tag, "pol", int'(pol_flags), int'(exp_pol));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_vs(input logic v);
        bit rising, falling;
        rising  = (v == 1'b1) && (vsync == 1'b0);
        falling = (v == 1'b0) && (vsync == 1'b1);
        vsync = v;
        if ((rising && !exp_pol[6]) || (falling && exp_pol[6])) begin
            q_due.push_back(cyc + 4); q_kind.push_back(1); q_val.push_back('0);
        end
    endtask

    task automatic send_frame(input logic [11:0] w, input int nbits, input bit tied);
        sel_n = 1'b0;
        if (tied) set_vs(1'b0);
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 12) ? w[11-i] : 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(2);
        end
        tick(4);
        sel_n = 1'b1;
        if (nbits == 12) begin
            q_due.push_back(cyc + 4); q_kind.push_back(0); q_val.push_back(w);
        end
        if (tied) set_vs(1'b1);
        tick(10);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(gain_code == 0 && aux_code == 0 && clamp_code == 0 && pol_flags == 0,
            "R1", "reset", {gain_code, aux_code, clamp_code, pol_flags}, 0);
        run = 1'b1;
        tick(2);

        // R2: ordering, gain pending (D9 set, must be dropped)
        cur_tag = "R2";
        send_frame({2'b00, 10'b10_0110_1001}, 12, 1'b0);
        chk(gain_code == 9'h000, "R2", "gain before sync", int'(gain_code), 0);
        set_vs(1'b1); tick(10);
        chk(gain_code == 9'h069, "R2", "gain after sync", int'(gain_code), 'h069);

        // R7: second gain write waits for the rising edge
        cur_tag = "R7";
        send_frame({2'b00, 10'h1C3}, 12, 1'b0);
        set_vs(1'b0); tick(10);
        chk(gain_code == 9'h069, "R7", "gain on inactive edge", int'(gain_code), 'h069);
        set_vs(1'b1); tick(10);
        chk(gain_code == 9'h1C3, "R7", "gain on active edge", int'(gain_code), 'h1C3);

        // R3 / R4: field masking
        cur_tag = "R3";
        send_frame({2'b01, 10'b11_1010_0101}, 12, 1'b0);
        chk(aux_code == 8'hA5, "R3", "aux", int'(aux_code), 'hA5);
        cur_tag = "R4";
        send_frame({2'b10, 10'h3FF}, 12, 1'b0);
        chk(clamp_code == 7'h7F, "R4", "clamp", int'(clamp_code), 'h7F);

        // R6: short and long frames ignored
        cur_tag = "R6";
        send_frame({2'b01, 10'h03C}, 11, 1'b0);
        chk(aux_code == 8'hA5, "R6", "aux after short frame", int'(aux_code), 'hA5);
        send_frame({2'b01, 10'h03C}, 13, 1'b0);
        chk(aux_code == 8'hA5, "R6", "aux after long frame", int'(aux_code), 'hA5);

        // R5: polarity, bit 4 reads zero, sync edge becomes falling
        cur_tag = "R5";
        send_frame({2'b11, 10'h3FF}, 12, 1'b0);
        chk(pol_flags == 7'h6F, "R5", "pol", int'(pol_flags), 'h6F);

        // R8: falling edge active now (vsync is high)
        cur_tag = "R8";
        send_frame({2'b00, 10'h0F0}, 12, 1'b0);
        set_vs(1'b0); tick(10);
        chk(gain_code == 9'h0F0, "R8", "gain on falling edge", int'(gain_code), 'hF0);
        send_frame({2'b00, 10'h155}, 12, 1'b0);
        set_vs(1'b1); tick(10);
        chk(gain_code == 9'h0F0, "R8", "gain on rising edge", int'(gain_code), 'hF0);
        set_vs(1'b0); tick(10);
        chk(gain_code == 9'h155, "R8", "gain on falling edge 2", int'(gain_code), 'h155);

        // R5: writing only D4 clears all flags
        cur_tag = "R5";
        send_frame({2'b11, 10'h010}, 12, 1'b0);
        chk(pol_flags == 7'h00, "R5", "pol bit4", int'(pol_flags), 0);

        // R9: select wired to sync, rising edge active
        cur_tag = "R9";
        send_frame({2'b00, 10'h0AA}, 12, 1'b1);
        chk(gain_code == 9'h0AA, "R9", "gain tied", int'(gain_code), 'hAA);
        set_vs(1'b0); tick(10);

        // R10: serial clock while deselected, then latency by model compare
        cur_tag = "R10";
        for (int i = 0; i < 14; i++) begin
            sdata = 1'b1; tick(3); sclk = 1'b1; tick(3); sclk = 1'b0; tick(2);
        end
        tick(8);
        chk(aux_code == 8'hA5 && clamp_code == 7'h7F, "R10", "idle sclk",
            {aux_code, clamp_code}, {8'hA5, 7'h7F});
        send_frame({2'b10, 10'h025}, 12, 1'b0);
        chk(clamp_code == 7'h25, "R10", "clamp", int'(clamp_code), 'h25);

        tick(5);
        run = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule